// File: doc/BRIEF.md
# Isochronous Split OUT Start-Split Sequencer

This block runs the start-split side of one isochronous OUT descriptor that a high-speed host sends through a transaction translator. The scheduler presents the descriptor's fields together with the low three bits of the frame index, and pulses `visit`, once in each microframe in which the descriptor is visited. The block answers one cycle later. It reports whether a start-split goes out in this microframe, which position code it carries and how many payload bytes it holds. It also returns every descriptor field in updated form, ready to be written back.

The start mask chooses the microframes in which a start-split may happen. The transaction count limits how many actually go out. Each start-split takes a slice of at most 188 bytes from the remaining byte count and decrements the transaction count. It also sets the progress bit of the current microframe. The descriptor retires when the count reaches zero.

A middle or final slice needs proof that the previous scheduled start-split really ran. If that proof is missing, the descriptor is aborted. A field combination that cannot describe a valid transfer is reported as an error and the descriptor is deactivated.

Top module: `iso_ss_seq`

## Requirements
- R1: While reset is asserted, and until the first visit after it, `ss_req`, `wb_valid`, `bad_fields` and `skip_abort` are all 0.
- R2: If `active_in` is 0 or `smask[uf_idx]` is 0, a visit issues nothing. The write-back then repeats every input field unchanged and both flags stay 0.
- R3: Each start-split lowers the count by one. `wb_active` drops exactly when the new count is zero. With a start mask that has at least as many bits set as the initial count, and no skipped visits, a descriptor issues exactly as many start-splits as its initial count.
- R4: A start-split carries `ss_len` = min(`bytes_in`, 188). `wb_bytes` equals `bytes_in` minus `ss_len`.
- R5: A descriptor with 0 bytes, count 1 and code ALL issues exactly one start-split with `ss_len` = 0, and then retires.
- R6: Position codes are ALL = 0, BEGIN = 1, MID = 2 and END = 3. `ss_pos` equals `pos_in`. After a BEGIN or MID slice, `wb_pos` becomes END if the new count is 1 and MID otherwise. After ALL or END it is unchanged.
- R7: A start-split sets bit `uf_idx` of `wb_prog` and leaves all other progress bits as given.
- R8: For code MID or END, the block finds the nearest start-mask bit below `uf_idx`. If there is none, or its progress bit is 0, the visit raises `skip_abort`, issues nothing, clears `wb_active` and leaves the other fields unchanged.
- R9: The fields are consistent only if both conditions hold. First, the count equals ceil(bytes/188), or bytes = 0 and count = 1. Second, the code is ALL or END when the count is 1, and BEGIN or MID otherwise. An inconsistent scheduled visit raises `bad_fields`, issues nothing and clears `wb_active`. This check takes precedence over R8.
- R10: All results appear on the cycle after the visit. `wb_valid` is a single-cycle pulse for each visit. At most one of `ss_req`, `bad_fields` and `skip_abort` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| visit | input | 1 | Descriptor is evaluated in this microframe |
| uf_idx | input | 3 | Frame index bits [2:0] |
| smask | input | 8 | Start mask, one bit per microframe |
| pos_in | input | 2 | Position code for the next slice |
| tcnt_in | input | 3 | Remaining start-split count |
| bytes_in | input | 10 | Remaining payload bytes |
| prog_in | input | 8 | Progress mask |
| active_in | input | 1 | Descriptor active |
| ss_req | output | 1 | Issue a start-split now |
| ss_pos | output | 2 | Position code of the start-split |
| ss_len | output | 8 | Payload length of the start-split |
| wb_valid | output | 1 | Write-back fields valid |
| wb_pos | output | 2 | Updated position code |
| wb_tcnt | output | 3 | Updated count |
| wb_bytes | output | 10 | Updated byte count |
| wb_prog | output | 8 | Updated progress mask |
| wb_active | output | 1 | Updated active flag |
| bad_fields | output | 1 | Inconsistent descriptor detected |
| skip_abort | output | 1 | Skipped start-split detected, descriptor aborted |

## Verification
The assertions assume three things about the inputs. The fields presented on a visit are the previous write-back, or a fresh descriptor. `visit` is never high in two adjacent cycles. Reset is released only with `visit` low. The bench respects all three. It drives a visit on one falling edge, lowers it on the next, and feeds the model's write-back into the following visit. It injects skipped microframes only by leaving a visit out, never by corrupting the fields. Inconsistent descriptors are applied as single fresh visits.

// File: rtl/iso_ss_pkg.sv
package iso_ss_pkg;
  localparam logic [1:0] POS_ALL   = 2'd0;
  localparam logic [1:0] POS_BEGIN = 2'd1;
  localparam logic [1:0] POS_MID   = 2'd2;
  localparam logic [1:0] POS_END   = 2'd3;
endpackage

// File: rtl/iso_ss_ufdec.sv
// Decodes the microframe bit and locates the previous scheduled slot.
module iso_ss_ufdec #(
  parameter int NUF = 8,
  localparam int UFW = $clog2(NUF)
) (
  input  logic [UFW-1:0] uf_idx,
  input  logic [NUF-1:0] smask,
  input  logic [NUF-1:0] prog,
  output logic [NUF-1:0] uf_bit,
  output logic           sched,
  output logic           prev_ok
);
  logic prev_found, prev_set;

  assign uf_bit = NUF'(1) << uf_idx;
  assign sched  = |(smask & uf_bit);

  // ascending scan: the last hit below uf_idx is the nearest one
  always_comb begin
    prev_found = 1'b0;
    prev_set   = 1'b0;
    for (int k = 0; k < NUF; k++) begin
      if ((UFW'(k) < uf_idx) && smask[k]) begin
        prev_found = 1'b1;
        prev_set   = prog[k];
      end
    end
  end

  assign prev_ok = prev_found && prev_set;
endmodule

// File: rtl/iso_ss_fchk.sv
// Consistency of count, byte total and position code.
module iso_ss_fchk #(
  parameter int CW    = 3,
  parameter int BW    = 10,
  parameter int SLICE = 188
) (
  input  logic [1:0]    pos,
  input  logic [CW-1:0] tcnt,
  input  logic [BW-1:0] bytes,
  output logic          ok
);
  import iso_ss_pkg::*;
  localparam int MW = CW + $clog2(SLICE + 1);
  localparam int SW = ((BW > MW) ? BW : MW) + 1;

  logic [SW-1:0] hi, lo, by;
  logic range_ok, zero_ok, one_left, pos_ok;

  assign by       = SW'(bytes);
  assign hi       = SW'(tcnt) * SW'(SLICE);
  assign lo       = hi - SW'(SLICE);
  assign range_ok = (tcnt != '0) && (by > lo) && (by <= hi);
  assign one_left = (tcnt == CW'(1));
  assign zero_ok  = (bytes == '0) && one_left;
  assign pos_ok   = one_left ? ((pos == POS_ALL) || (pos == POS_END))
                             : ((pos == POS_BEGIN) || (pos == POS_MID));
  assign ok       = (range_ok || zero_ok) && pos_ok;
endmodule

// File: rtl/iso_ss_seq.sv
module iso_ss_seq #(
  parameter int NUF   = 8,
  parameter int CW    = 3,
  parameter int BW    = 10,
  parameter int SLICE = 188,
  localparam int UFW  = $clog2(NUF),
  localparam int LW   = $clog2(SLICE + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           visit,
  input  logic [UFW-1:0] uf_idx,
  input  logic [NUF-1:0] smask,
  input  logic [1:0]     pos_in,
  input  logic [CW-1:0]  tcnt_in,
  input  logic [BW-1:0]  bytes_in,
  input  logic [NUF-1:0] prog_in,
  input  logic           active_in,
  output logic           ss_req,
  output logic [1:0]     ss_pos,
  output logic [LW-1:0]  ss_len,
  output logic           wb_valid,
  output logic [1:0]     wb_pos,
  output logic [CW-1:0]  wb_tcnt,
  output logic [BW-1:0]  wb_bytes,
  output logic [NUF-1:0] wb_prog,
  output logic           wb_active,
  output logic           bad_fields,
  output logic           skip_abort
);
  import iso_ss_pkg::*;

  logic [NUF-1:0] uf_bit;
  logic           sched, prev_ok, fields_ok;

  iso_ss_ufdec #(.NUF(NUF)) u_dec (
    .uf_idx(uf_idx), .smask(smask), .prog(prog_in),
    .uf_bit(uf_bit), .sched(sched), .prev_ok(prev_ok)
  );

  iso_ss_fchk #(.CW(CW), .BW(BW), .SLICE(SLICE)) u_fchk (
    .pos(pos_in), .tcnt(tcnt_in), .bytes(bytes_in), .ok(fields_ok)
  );

  logic           n_req, n_bad, n_skip, n_act, cont;
  logic [1:0]     n_pos;
  logic [LW-1:0]  n_len;
  logic [CW-1:0]  n_tc, tc_dec;
  logic [BW-1:0]  n_by;
  logic [NUF-1:0] n_prog;

  assign tc_dec = tcnt_in - CW'(1);
  assign cont   = (pos_in == POS_BEGIN) || (pos_in == POS_MID);

  always_comb begin
    n_req  = 1'b0;
    n_bad  = 1'b0;
    n_skip = 1'b0;
    n_pos  = pos_in;
    n_len  = '0;
    n_tc   = tcnt_in;
    n_by   = bytes_in;
    n_prog = prog_in;
    n_act  = active_in;
    if (visit && active_in && sched) begin
      if (!fields_ok) begin
        n_bad = 1'b1;
        n_act = 1'b0;
      end else if (pos_in[1] && !prev_ok) begin
        // MID or END without proof of the preceding start-split
        n_skip = 1'b1;
        n_act  = 1'b0;
      end else begin
        n_req  = 1'b1;
        n_len  = (bytes_in > BW'(SLICE)) ? LW'(SLICE) : LW'(bytes_in);
        n_by   = bytes_in - BW'(n_len);
        n_tc   = tc_dec;
        n_prog = prog_in | uf_bit;
        n_act  = (tc_dec != '0);
        if (cont) n_pos = (tc_dec == CW'(1)) ? POS_END : POS_MID;
      end
    end
  end

  // single-cycle indications
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_req     <= 1'b0;
      wb_valid   <= 1'b0;
      bad_fields <= 1'b0;
      skip_abort <= 1'b0;
    end else begin
      ss_req     <= n_req;
      wb_valid   <= visit;
      bad_fields <= n_bad;
      skip_abort <= n_skip;
    end
  end

  // payload and write-back fields, enabled by visit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_pos    <= '0;
      ss_len    <= '0;
      wb_pos    <= '0;
      wb_tcnt   <= '0;
      wb_bytes  <= '0;
      wb_prog   <= '0;
      wb_active <= 1'b0;
    end else if (visit) begin
      ss_pos    <= pos_in;
      ss_len    <= n_len;
      wb_pos    <= n_pos;
      wb_tcnt   <= n_tc;
      wb_bytes  <= n_by;
      wb_prog   <= n_prog;
      wb_active <= n_act;
    end
  end
endmodule

// File: rtl/iso_ss_chk.sv
module iso_ss_chk #(
  parameter int NUF   = 8,
  parameter int CW    = 3,
  parameter int BW    = 10,
  parameter int SLICE = 188,
  localparam int UFW  = $clog2(NUF),
  localparam int LW   = $clog2(SLICE + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           visit,
  input logic [UFW-1:0] uf_idx,
  input logic [CW-1:0]  tcnt_in,
  input logic           ss_req,
  input logic [LW-1:0]  ss_len,
  input logic           wb_valid,
  input logic [CW-1:0]  wb_tcnt,
  input logic [NUF-1:0] wb_prog,
  input logic           wb_active,
  input logic           bad_fields,
  input logic           skip_abort
);
  a_r4_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    ss_req |-> (ss_len <= LW'(SLICE)));

  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ss_req, bad_fields, skip_abort}));

  a_r10_follows_visit: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_req || wb_valid) |-> $past(visit));

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    ss_req |-> (wb_tcnt == $past(tcnt_in) - CW'(1)));

  a_r3_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_req && (wb_tcnt == '0)) |-> !wb_active);

  a_r8_abort_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_abort || bad_fields) |-> (wb_valid && !wb_active));

  a_r7_prog_mark: assert property (@(posedge clk) disable iff (!rst_n)
    ss_req |-> wb_prog[$past(uf_idx)]);
endmodule

bind iso_ss_seq iso_ss_chk #(.NUF(NUF), .CW(CW), .BW(BW), .SLICE(SLICE)) u_chk (.*);

// File: tb/sim_iso_ss_seq.sv
module sim_iso_ss_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       visit = 1'b0;
  logic [2:0] uf_idx = '0;
  logic [7:0] smask = '0;
  logic [1:0] pos_in = '0;
  logic [2:0] tcnt_in = '0;
  logic [9:0] bytes_in = '0;
  logic [7:0] prog_in = '0;
  logic       active_in = 1'b0;
  logic       ss_req, wb_valid, wb_active, bad_fields, skip_abort;
  logic [1:0] ss_pos, wb_pos;
  logic [7:0] ss_len, wb_prog;
  logic [2:0] wb_tcnt;
  logic [9:0] wb_bytes;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  iso_ss_seq u0 (
    .clk(clk), .rst_n(rst_n), .visit(visit), .uf_idx(uf_idx), .smask(smask),
    .pos_in(pos_in), .tcnt_in(tcnt_in), .bytes_in(bytes_in), .prog_in(prog_in),
    .active_in(active_in), .ss_req(ss_req), .ss_pos(ss_pos), .ss_len(ss_len),
    .wb_valid(wb_valid), .wb_pos(wb_pos), .wb_tcnt(wb_tcnt), .wb_bytes(wb_bytes),
    .wb_prog(wb_prog), .wb_active(wb_active), .bad_fields(bad_fields),
    .skip_abort(skip_abort)
  );

  typedef struct {
    bit req; int pos; int len; int tc; int by; int pg; bit act; bit bad; bit skip;
  } exp_t;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expectation derived from the requirement text
  function automatic exp_t model(input int uf, input int sm, input int p, input int tc,
                                 input int by, input int pg, input bit ac);
    exp_t e;
    int need, prev;
    bit posok;
    e = '{req:0, pos:p, len:0, tc:tc, by:by, pg:pg, act:ac, bad:0, skip:0};
    if (ac && sm[uf]) begin
      need  = (by == 0) ? 1 : (by + 187) / 188;
      posok = (tc == 1) ? (p == 0 || p == 3) : (p == 1 || p == 2);
      if (tc != need || !posok) begin
        e.bad = 1; e.act = 0;
      end else begin
        prev = -1;
        for (int k = uf - 1; k >= 0; k--) if (prev < 0 && sm[k]) prev = k;
        if (p >= 2 && (prev < 0 || !pg[prev])) begin
          e.skip = 1; e.act = 0;
        end else begin
          e.req = 1;
          e.len = (by < 188) ? by : 188;
          e.by  = by - e.len;
          e.tc  = tc - 1;
          e.pg  = pg | (1 << uf);
          e.act = (e.tc != 0);
          if (p == 1 || p == 2) e.pos = (e.tc == 1) ? 3 : 2;
        end
      end
    end
    return e;
  endfunction

  task automatic do_visit(input int uf, input int sm, input int p, input int tc,
                          input int by, input int pg, input bit ac, output exp_t e);
    e = model(uf, sm, p, tc, by, pg, ac);
    @(negedge clk);
    visit = 1'b1; uf_idx = 3'(uf); smask = 8'(sm); pos_in = 2'(p);
    tcnt_in = 3'(tc); bytes_in = 10'(by); prog_in = 8'(pg); active_in = ac;
    @(negedge clk);
    visit = 1'b0;
    chk(wb_valid == 1'b1, "R10 wb_valid", int'(wb_valid), 1);
    chk(ss_req == e.req, "R2 ss_req", int'(ss_req), int'(e.req));
    if (e.req) begin
      chk(ss_pos == 2'(p), "R6 ss_pos", int'(ss_pos), p);
      chk(ss_len == 8'(e.len), "R4 ss_len", int'(ss_len), e.len);
    end
    chk(wb_pos == 2'(e.pos), "R6 wb_pos", int'(wb_pos), e.pos);
    chk(wb_tcnt == 3'(e.tc), "R3 wb_tcnt", int'(wb_tcnt), e.tc);
    chk(wb_bytes == 10'(e.by), "R4 wb_bytes", int'(wb_bytes), e.by);
    chk(wb_prog == 8'(e.pg), "R7 wb_prog", int'(wb_prog), e.pg);
    chk(wb_active == e.act, "R3 wb_active", int'(wb_active), int'(e.act));
    chk(bad_fields == e.bad, "R9 bad_fields", int'(bad_fields), int'(e.bad));
    chk(skip_abort == e.skip, "R8 skip_abort", int'(skip_abort), int'(e.skip));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int blist[9] = '{0, 1, 187, 188, 189, 376, 377, 564, 900};
    exp_t e;
    int tc0, sm, st_p, st_tc, st_by, st_pg, issued;
    bit st_ac;

    repeat (3) @(negedge clk);
    chk(!ss_req && !wb_valid && !bad_fields && !skip_abort, "R1 in reset",
        int'({ss_req, wb_valid, bad_fields, skip_abort}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ss_req && !wb_valid && !bad_fields && !skip_abort, "R1 after release",
        int'({ss_req, wb_valid, bad_fields, skip_abort}), 0);

    // R5: zero-length single start-split, then retired
    do_visit(0, 8'hFF, 0, 1, 0, 0, 1'b1, e);
    chk(ss_req && ss_len == 0 && !wb_active, "R5 zero-length slice",
        int'({ss_req, ss_len}), 256);
    do_visit(1, 8'hFF, int'(wb_pos), int'(wb_tcnt), int'(wb_bytes), int'(wb_prog),
             wb_active, e);
    chk(!ss_req, "R5 no second slice", int'(ss_req), 0);

    // R2 / R10: unscheduled slot echoes fields, pulse lasts one cycle
    do_visit(2, 8'h03, 1, 2, 300, 8'h5A, 1'b1, e);
    @(negedge clk);
    chk(!wb_valid && !ss_req, "R10 pulse width", int'(wb_valid), 0);

    // inconsistent fields sweep (R9)
    for (int t = 0; t < 8; t++)
      for (int b = 0; b < 9; b++)
        for (int p = 0; p < 4; p++)
          do_visit(3, 8'hFF, p, t, blist[b], 8'h04, 1'b1, e);

    // full-descriptor sweeps with optional dropped microframe (R3, R8)
    for (int mi = 0; mi < 15; mi++) begin
      sm = (1 + mi * 17) & 8'hFF;
      for (int b = 0; b < 9; b++) begin
        tc0 = (blist[b] == 0) ? 1 : (blist[b] + 187) / 188;
        for (int drop = 0; drop < 9; drop++) begin
          st_p = (tc0 == 1) ? 0 : 1; st_tc = tc0; st_by = blist[b];
          st_pg = 0; st_ac = 1'b1; issued = 0;
          for (int uf = 0; uf < 8; uf++) begin
            if (uf != drop) begin
              do_visit(uf, sm, st_p, st_tc, st_by, st_pg, st_ac, e);
              if (ss_req) issued++;
              st_p = e.pos; st_tc = e.tc; st_by = e.by; st_pg = e.pg; st_ac = e.act;
            end
          end
          if (drop == 8 && $countones(8'(sm)) >= tc0)
            chk(issued == tc0, "R3 start-split total", issued, tc0);
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule